// File: doc/BRIEF.md
# Jacobi 2×2 Rotation Unit

This block carries out a single two-sided Jacobi step on a symmetric 2×2 block whose diagonal holds `x` and `y` and whose two off-diagonal entries both equal `w`. It finds an angle θ with tan 2θ = 2w / (y − x). The unit then forms the rotated block Jᵀ·A·J with J = [cos θ, sin θ; −sin θ, cos θ]. The off-diagonal term of that block is zero, and the unit returns its new diagonal pair together with θ, cos θ and sin θ.

All values are signed fixed point with 2 integer bits and 30 fraction bits. The angle search is an iterative CORDIC in vectoring mode that does one micro-rotation per clock. A second CORDIC pass in rotation mode, run on the same registers, turns θ into cos θ and sin θ. Its gain is cancelled by a preloaded constant. Products are formed at full width and truncated back to the working width before they are used again. A sweep controller can issue a request in the cycle `done` is high, so requests can follow each other with no gap.

Top module: `jacobi_rot2`

## Requirements
- R1: After reset `busy` and `done` are low and `xOut`, `yOut`, `cosOut`, `sinOut` and `thetaOut` are all zero.
- R2: `start` is taken, together with `xIn`, `wIn` and `yIn`, only on a clock edge where `busy` is low. A `start` seen while busy has no effect: it does not change the result and produces no extra `done`.
- R3: `done` is high for one cycle per accepted request. The outputs change only on the edge that raises `done` and hold their values at all other times.
- R4: With `wIn` non-zero, `done` is high after the (2·ITERS+3)-th edge following the accepting edge, which is 63 edges for the default ITERS = 30. With `wIn` zero, `done` is high right after the accepting edge.
- R5: With `wIn` zero, the outputs are `thetaOut` = 0, `cosOut` = 32'h4000_0000 (1.0), `sinOut` = 0, and `xOut`/`yOut` equal to `xIn`/`yIn` bit for bit.
- R6: `thetaOut` equals atan2(2w, y − x)/2 within 1e-5 rad. It lies in (−π/2, π/2] and is coded as two's complement radians with 30 fraction bits.
- R7: `cosOut` and `sinOut` equal cos θ and sin θ of the true angle, each within 2e-5.
- R8: `xOut` ≈ x·c² − 2·w·c·s + y·s² and `yOut` ≈ x·s² + 2·w·c·s + y·c², each within 1e-4. The off-diagonal term c·s·(x − y) + w·(c² − s²), formed from the output cosine and sine, stays below 1e-4 in magnitude.
- R9: The trace is preserved exactly: `xOut + yOut` equals `xIn + yIn` bit for bit, taken modulo 2^32.
- R10: A request raised in the cycle where `done` is high is accepted on the next edge and completes with the normal latency and correct results.
- R11: All four sign combinations of (y − x, w) are handled, including y − x < 0, where |θ| exceeds π/4, and y − x = 0, where θ = ±π/4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| xIn | input | 32 | Upper diagonal entry, Q2.30 |
| wIn | input | 32 | Off-diagonal entry, Q2.30 |
| yIn | input | 32 | Lower diagonal entry, Q2.30 |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| xOut | output | 32 | New upper diagonal entry, Q2.30 |
| yOut | output | 32 | New lower diagonal entry, Q2.30 |
| cosOut | output | 32 | cos θ, Q2.30 |
| sinOut | output | 32 | sin θ, Q2.30 |
| thetaOut | output | 32 | Rotation angle θ in radians, Q2.30 |

## Verification
A wrong sign decision in any micro-rotation, or a bad entry in the arctangent table, moves `thetaOut` and `cosOut`/`sinOut` away from the true angle. It also leaves a visible residual in the off-diagonal term recomputed from the outputs, on the same `done` pulse as the request that caused it. A controller that miscounts iterations or states shows up as a `done` arriving on the wrong edge. A register overwritten during a busy period shows up as a result that belongs to the wrong request. The exact trace relation catches a broken final mixing stage even when the error is too small to exceed the real-valued tolerances.

// File: rtl/jacobi_rot2_pkg.sv
package jacobi_rot2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_SETUP,
    ST_ROT,
    ST_PROD,
    ST_MIX
  } jrState_t;

  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;      // capture operands, seed vectoring pass
    logic bypass;    // zero off-diagonal: publish inputs directly
    logic vecStep;   // one vectoring micro-rotation
    logic rotInit;   // halve angle, seed rotation pass
    logic rotStep;   // one rotation micro-rotation
    logic prodStep;  // form c*c, s*s, c*s
    logic mixStep;   // form new diagonal pair, publish
  } jrStrobe_t;

endpackage

// File: rtl/jacobi_rot2_ctrl.sv
module jacobi_rot2_ctrl
  import jacobi_rot2_pkg::*;
#(
  parameter int ITERS = 30,
  localparam int IW = $clog2(ITERS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wZero,
  output jrStrobe_t     strb,
  output logic [IW-1:0] iter,
  output logic          busy,
  output logic          done
);

  localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

  jrState_t state, stateNxt;
  logic     lastIter;

  assign lastIter = (iter == LAST);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (wZero) begin
            strb.bypass = 1'b1;
          end else begin
            strb.load = 1'b1;
            stateNxt  = ST_VEC;
          end
        end
      end
      ST_VEC: begin
        strb.vecStep = 1'b1;
        if (lastIter) stateNxt = ST_SETUP;
      end
      ST_SETUP: begin
        strb.rotInit = 1'b1;
        stateNxt     = ST_ROT;
      end
      ST_ROT: begin
        strb.rotStep = 1'b1;
        if (lastIter) stateNxt = ST_PROD;
      end
      ST_PROD: begin
        strb.prodStep = 1'b1;
        stateNxt      = ST_MIX;
      end
      ST_MIX: begin
        strb.mixStep = 1'b1;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= strb.bypass | strb.mixStep;
      if ((strb.vecStep || strb.rotStep) && !lastIter) iter <= iter + 1'b1;
      else                                             iter <= '0;
    end
  end

endmodule

// File: rtl/jacobi_rot2_dp.sv
module jacobi_rot2_dp
  import jacobi_rot2_pkg::*;
#(
  parameter int DW    = 32,
  parameter int FW    = 30,   // at most 30
  parameter int ITERS = 30,   // at most 30
  localparam int IW = $clog2(ITERS),
  localparam int GW = DW + 3  // guard bits for 2w, y-x and CORDIC gain
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  jrStrobe_t            strb,
  input  logic [IW-1:0]        iter,
  input  logic signed [DW-1:0] xIn,
  input  logic signed [DW-1:0] wIn,
  input  logic signed [DW-1:0] yIn,
  output logic                 wZero,
  output logic signed [DW-1:0] xOut,
  output logic signed [DW-1:0] yOut,
  output logic signed [DW-1:0] cosOut,
  output logic signed [DW-1:0] sinOut,
  output logic signed [DW-1:0] thetaOut
);

  // atan(1/n) scaled by 2^60, power series
  function automatic longint atanRecip(input longint n);
    longint term, sum, nsq;
    sum  = 0;
    term = (longint'(1) <<< 60) / n;
    nsq  = n * n;
    for (int k = 0; k < 64; k++) begin
      if (k % 2 == 0) sum = sum + term / longint'(2 * k + 1);
      else            sum = sum - term / longint'(2 * k + 1);
      term = term / nsq;
    end
    return sum;
  endfunction

  function automatic logic [GW-1:0] toFw(input longint v60);
    logic [63:0] t;
    t = 64'((v60 + (longint'(1) <<< (59 - FW))) >>> (60 - FW));
    return t[GW-1:0];
  endfunction

  function automatic logic [ITERS*GW-1:0] buildAtan();
    logic [ITERS*GW-1:0] tab;
    tab = '0;
    for (int i = 0; i < ITERS; i++) begin
      if (i == 0) tab[0 +: GW] = toFw(atanRecip(2) + atanRecip(3));
      else        tab[i*GW +: GW] = toFw(atanRecip(longint'(1) <<< i));
    end
    return tab;
  endfunction

  function automatic logic signed [GW-1:0] mulQ(input logic signed [GW-1:0] a,
                                                input logic signed [GW-1:0] b);
    logic signed [2*GW-1:0] p;
    p = (2*GW)'(a) * (2*GW)'(b);
    return p[FW +: GW];
  endfunction

  localparam logic [ITERS*GW-1:0] ATAN_ALL = buildAtan();
  localparam logic signed [GW-1:0] PI_Q = toFw(4 * (atanRecip(2) + atanRecip(3)));
  localparam logic signed [GW-1:0] KINV = GW'(64'd652032874 >> (30 - FW));
  localparam logic signed [GW-1:0] ONE  = GW'(1) <<< FW;

  logic signed [GW-1:0] xR, wR, yR;
  logic signed [GW-1:0] px, py, pz, thetaR;
  logic signed [GW-1:0] cc, ss, cs;
  logic signed [GW-1:0] xExt, wExt, yExt, dx, dy;
  logic signed [GW-1:0] atanI, pxSh, pySh, nx, ny, nz, xMix, yMix;
  logic                 goUp;

  assign wZero = (wIn == '0);
  assign xExt  = GW'(xIn);
  assign wExt  = GW'(wIn);
  assign yExt  = GW'(yIn);
  assign dx    = yExt - xExt;
  assign dy    = wExt <<< 1;

  assign atanI = ATAN_ALL[int'(iter)*GW +: GW];
  assign pxSh  = px >>> iter;
  assign pySh  = py >>> iter;

  // vectoring steers py to zero; rotation steers pz to zero
  assign goUp = strb.rotStep ? !pz[GW-1] : py[GW-1];

  always_comb begin
    if (goUp) begin
      nx = px - pySh;
      ny = py + pxSh;
      nz = strb.rotStep ? pz - atanI : pz - atanI;
    end else begin
      nx = px + pySh;
      ny = py - pxSh;
      nz = pz + atanI;
    end
  end

  assign xMix = mulQ(xR, cc) - (mulQ(wR, cs) <<< 1) + mulQ(yR, ss);
  assign yMix = xR + yR - xMix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR <= '0; wR <= '0; yR <= '0;
      px <= '0; py <= '0; pz <= '0; thetaR <= '0;
      cc <= '0; ss <= '0; cs <= '0;
      xOut <= '0; yOut <= '0; cosOut <= '0; sinOut <= '0; thetaOut <= '0;
    end else begin
      if (strb.load) begin
        xR <= xExt;
        wR <= wExt;
        yR <= yExt;
        if (dx[GW-1]) begin
          px <= -dx;
          py <= -dy;
          pz <= wIn[DW-1] ? -PI_Q : PI_Q;
        end else begin
          px <= dx;
          py <= dy;
          pz <= '0;
        end
      end
      if (strb.vecStep || strb.rotStep) begin
        px <= nx;
        py <= ny;
        pz <= nz;
      end
      if (strb.rotInit) begin
        thetaR <= pz >>> 1;
        pz     <= pz >>> 1;
        px     <= KINV;
        py     <= '0;
      end
      if (strb.prodStep) begin
        cc <= mulQ(px, px);
        ss <= mulQ(py, py);
        cs <= mulQ(px, py);
      end
      if (strb.mixStep) begin
        xOut     <= xMix[DW-1:0];
        yOut     <= yMix[DW-1:0];
        cosOut   <= px[DW-1:0];
        sinOut   <= py[DW-1:0];
        thetaOut <= thetaR[DW-1:0];
      end
      if (strb.bypass) begin
        xOut     <= xIn;
        yOut     <= yIn;
        cosOut   <= ONE[DW-1:0];
        sinOut   <= '0;
        thetaOut <= '0;
      end
    end
  end

endmodule

// File: rtl/jacobi_rot2.sv
module jacobi_rot2
  import jacobi_rot2_pkg::*;
#(
  parameter int DW    = 32,
  parameter int FW    = 30,
  parameter int ITERS = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic signed [DW-1:0] xIn,
  input  logic signed [DW-1:0] wIn,
  input  logic signed [DW-1:0] yIn,
  output logic                 busy,
  output logic                 done,
  output logic signed [DW-1:0] xOut,
  output logic signed [DW-1:0] yOut,
  output logic signed [DW-1:0] cosOut,
  output logic signed [DW-1:0] sinOut,
  output logic signed [DW-1:0] thetaOut
);

  localparam int IW = $clog2(ITERS);

  jrStrobe_t     strb;
  logic [IW-1:0] iter;
  logic          wZero;

  jacobi_rot2_ctrl #(.ITERS(ITERS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .wZero(wZero),
    .strb(strb), .iter(iter), .busy(busy), .done(done)
  );

  jacobi_rot2_dp #(.DW(DW), .FW(FW), .ITERS(ITERS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .iter(iter),
    .xIn(xIn), .wIn(wIn), .yIn(yIn), .wZero(wZero),
    .xOut(xOut), .yOut(yOut), .cosOut(cosOut), .sinOut(sinOut), .thetaOut(thetaOut)
  );

endmodule

// File: rtl/jacobi_rot2_chk.sv
module jacobi_rot2_chk #(
  parameter int DW    = 32,
  parameter int ITERS = 30
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic signed [DW-1:0] xIn,
  input logic signed [DW-1:0] wIn,
  input logic signed [DW-1:0] yIn,
  input logic                 busy,
  input logic                 done,
  input logic signed [DW-1:0] xOut,
  input logic signed [DW-1:0] yOut,
  input logic signed [DW-1:0] cosOut,
  input logic signed [DW-1:0] sinOut,
  input logic signed [DW-1:0] thetaOut
);

  localparam int LAT = 2 * ITERS + 3;

  logic [15:0] lat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lat <= '0;
    else if (start && !busy)  lat <= '0;
    else if (busy)            lat <= lat + 1'b1;
  end

  // R2: an idle start is always taken
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy || done));

  // R3: single-cycle done unless a zero-w request follows at once
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(start && wIn == '0)) |=> !done);

  // R3: outputs only move with done
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(xOut) && $stable(yOut) && $stable(cosOut) &&
               $stable(sinOut) && $stable(thetaOut)));

  // R4: fixed latency for a rotating request, zero for a bypass
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lat == 16'(LAT) || lat == '0));

  // R5: zero off-diagonal passes straight through
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && wIn == '0) |=>
      (done && thetaOut == '0 && sinOut == '0 &&
       xOut == $past(xIn) && yOut == $past(yIn)));

  // R9: trace kept across a completed request
  a_r9_trace: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && wIn == '0) |=> (DW'(xOut + yOut) == DW'($past(xIn) + $past(yIn))));

endmodule

bind jacobi_rot2 jacobi_rot2_chk #(.DW(DW), .ITERS(ITERS)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .wIn(wIn), .yIn(yIn),
  .busy(busy), .done(done), .xOut(xOut), .yOut(yOut), .cosOut(cosOut),
  .sinOut(sinOut), .thetaOut(thetaOut)
);

// File: tb/jacobi_rot2_tb_top.sv
`timescale 1ns/1ps
module jacobi_rot2_tb_top;

  localparam real SCALE = 1073741824.0;  // 2^30
  localparam int  LATN  = 63;            // 2*ITERS+3

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [31:0] xIn = '0, wIn = '0, yIn = '0;
  logic busy, done;
  logic signed [31:0] xOut, yOut, cosOut, sinOut, thetaOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  jacobi_rot2 dut_i (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .wIn(wIn), .yIn(yIn),
    .busy(busy), .done(done), .xOut(xOut), .yOut(yOut), .cosOut(cosOut),
    .sinOut(sinOut), .thetaOut(thetaOut)
  );

  function automatic logic signed [31:0] toQ(input real r);
    return 32'($rtoi(r * SCALE));
  endfunction

  function automatic real fromQ(input logic signed [31:0] v);
    return $itor(v) / SCALE;
  endfunction

  task automatic chkInt(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkReal(input string tag, input real act, input real exp, input real tol);
    real d;
    checks++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual %f expected %f", tag, act, exp);
    end
  endtask

  // raise start for one edge, then wait for done; n = edges after the accepting one
  task automatic issue(input logic signed [31:0] xq, wq, yq, output int n);
    xIn = xq; wIn = wq; yIn = yq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkResult(input string tag, input logic signed [31:0] xq, wq, yq, input int n);
    real x, w, y, th, c, s, co, so, off;
    x = fromQ(xq); w = fromQ(wq); y = fromQ(yq);
    chkInt({tag, " R4 latency"}, n, (wq == 0) ? 0 : LATN);
    chkInt({tag, " R9 trace"}, 32'(xOut + yOut), 32'(xq + yq));
    if (wq == 0) begin
      chkInt({tag, " R5 xOut"}, xOut, xq);
      chkInt({tag, " R5 yOut"}, yOut, yq);
      chkInt({tag, " R5 cos"}, cosOut, 32'sh4000_0000);
      chkInt({tag, " R5 sin"}, sinOut, 0);
      chkInt({tag, " R5 theta"}, thetaOut, 0);
    end else begin
      th = $atan2(2.0 * w, y - x) / 2.0;
      c = $cos(th); s = $sin(th);
      chkReal({tag, " R6 theta"}, fromQ(thetaOut), th, 1e-5);
      chkReal({tag, " R7 cos"}, fromQ(cosOut), c, 2e-5);
      chkReal({tag, " R7 sin"}, fromQ(sinOut), s, 2e-5);
      chkReal({tag, " R8 xOut"}, fromQ(xOut), x*c*c - 2.0*w*c*s + y*s*s, 1e-4);
      chkReal({tag, " R8 yOut"}, fromQ(yOut), x*s*s + 2.0*w*c*s + y*c*c, 1e-4);
      co = fromQ(cosOut); so = fromQ(sinOut);
      off = co*so*(x - y) + w*(co*co - so*so);
      chkReal({tag, " R8 offdiag"}, off, 0.0, 1e-4);
    end
  endtask

  task automatic runReq(input string tag, input real xr, wr, yr);
    int n;
    logic signed [31:0] xq, wq, yq;
    xq = toQ(xr); wq = toQ(wr); yq = toQ(yr);
    issue(xq, wq, yq, n);
    checkResult(tag, xq, wq, yq, n);
    @(negedge clk);
    chkInt({tag, " R3 done one cycle"}, done, 0);
  endtask

  task automatic testReset();
    chkInt("R1 busy", busy, 0);
    chkInt("R1 done", done, 0);
    chkInt("R1 xOut", xOut, 0);
    chkInt("R1 yOut", yOut, 0);
    chkInt("R1 cos", cosOut, 0);
    chkInt("R1 sin", sinOut, 0);
    chkInt("R1 theta", thetaOut, 0);
  endtask

  // R2: second start during busy must be ignored
  task automatic testBusyIgnore();
    int n, extra;
    logic signed [31:0] xq, wq, yq, xKeep;
    xq = toQ(0.25); wq = toQ(-0.15); yq = toQ(0.55);
    xIn = xq; wIn = wq; yIn = yq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    chkInt("R2 busy mid-run", busy, 1);
    xIn = toQ(-0.6); wIn = toQ(0.4); yIn = toQ(0.1); start = 1'b1;
    @(negedge clk); n++;
    start = 1'b0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    checkResult("R2 first request kept", xq, wq, yq, n);
    xKeep = xOut;
    extra = 0;
    repeat (80) begin @(negedge clk); if (done) extra++; end
    chkInt("R2 no extra done", extra, 0);
    chkInt("R2 output unchanged", xOut, xKeep);
  endtask

  // R10: request in the done cycle
  task automatic testBackToBack();
    int n;
    logic signed [31:0] aX, aW, aY, bX, bW, bY;
    aX = toQ(0.1); aW = toQ(0.2); aY = toQ(-0.3);
    bX = toQ(-0.2); bW = toQ(-0.45); bY = toQ(0.35);
    issue(aX, aW, aY, n);
    checkResult("R10 first", aX, aW, aY, n);
    chkInt("R10 done high at reissue", done, 1);
    issue(bX, bW, bY, n);
    checkResult("R10 second", bX, bW, bY, n);
    issue(toQ(0.4), 0, toQ(-0.4), n);
    checkResult("R10 bypass after done", toQ(0.4), 0, toQ(-0.4), n);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runReq("R6 basic dx>0", 0.1, 0.3, 0.6);
    runReq("R11 dx<0 w>0", 0.5, 0.25, 0.1);
    runReq("R11 dx=0 w<0", 0.4, -0.35, 0.4);
    runReq("R11 dx<0 w<0", 0.6, -0.2, -0.5);
    runReq("R6 small w", -0.7, 0.05, 0.2);
    runReq("R11 dx<0 small w", 0.7, 0.02, -0.1);
    runReq("R5 zero w", 0.3, 0.0, 0.7);
    runReq("R5 zero w swapped", 0.7, 0.0, -0.3);
    testBusyIgnore();
    testBackToBack();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule